// File: doc/BRIEF.md
# Opcode-Configurable Neural Processing Element

This block is a single arithmetic element for a neural-network datapath. A thread-level controller picks its operator every cycle with an opcode. The same datapath then acts as a multiply-accumulator for convolution and fully connected layers, as a running max or min comparator for pooling, or as a two-operand adder for shortcut layers. After that, a selectable nonlinearity is applied: bypass, ReLU, sigmoid or tanh. Sigmoid and tanh are piecewise-linear curves that need only shifts and adds.

Each operand is a signed fixed-point value with FRAC_W fractional bits (Q4.4 by default, so 1.0 is 16). The accumulator is wider than the operands and saturates instead of wrapping. A valid strobe qualifies each operation. A first flag starts a new window, and a last flag ends it. One cycle after the last operation of a window, the element presents an 8-bit saturated result and pulses its output valid.

Top module: `opcfg_pe`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset is released, valid_o is 0 and y_o is 0. Reset also clears the accumulator, so a later accumulate without first_i adds to zero.
- R2: Opcode 0 (multiply-accumulate) loads a_i*w_i into the accumulator when first_i is 1 and adds it otherwise. The value used for the output is the accumulator shifted arithmetically right by FRAC_W (4).
- R3: Opcode 4 (clear) sets the accumulator to zero and never produces an output. Opcodes 5 to 7 leave the accumulator unchanged and produce no output.
- R4: Opcodes 1 (max) and 2 (min) load a_i when first_i is 1. Otherwise they keep the larger (max) or smaller (min) of a_i and the accumulator. The result is not shifted.
- R5: Opcode 3 (add) loads a_i+b_i into the accumulator whatever first_i is. The result is not shifted.
- R6: When valid_i is 0 the accumulator holds and no output is produced. valid_o is a one-cycle pulse in the cycle after an accepted operation with opcode 0 to 3 and last_i set. y_o keeps its value until the next such pulse.
- R7: With act_i 0 (bypass), y_o is the result saturated to the range -128..127.
- R8: With act_i 1 (ReLU), a negative result gives 0. Other results are saturated as in R7.
- R9: With act_i 3 (tanh), let u be |x| limited to 64. The curve g(u) is: u for u<8, 8+(u-8)/2 for u<16, 12+(u-16)/4 for u<32, and 16 otherwise, where each division truncates. y_o is g(u) for x≥0 and -g(u) for x<0, so the output stays within -16..16.
- R10: With act_i 2 (sigmoid), y_o is 8+g(u/2)/2 for x≥0 and 8-g(u/2)/2 for x<0, with g and u as in R9. The output stays within 0..16, and x=0 gives 8.
- R11: The accumulator saturates at +8388607 and -8388608 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the operation presented this cycle |
| op_i | input | 3 | Operator: 0 MAC, 1 max, 2 min, 3 add, 4 clear |
| act_i | input | 2 | Nonlinearity: 0 bypass, 1 ReLU, 2 sigmoid, 3 tanh |
| first_i | input | 1 | First operation of a window; loads instead of combining |
| last_i | input | 1 | Last operation of a window; requests an output |
| a_i | input | 8 | Signed activation operand A |
| b_i | input | 8 | Signed activation operand B (add only) |
| w_i | input | 8 | Signed weight operand |
| y_o | output | 8 | Signed saturated result |
| valid_o | output | 1 | One-cycle pulse marking a new y_o |

## Verification
Every result is due exactly one rising edge after the operation that carries last_i. The bench drives inputs just after a falling edge and reads y_o and valid_o at the next falling edge, which is one register stage later. Operations without last_i, and idle cycles, are checked at the same point for valid_o low, so an early or extra pulse is caught. The saturation tests run hundreds of accumulate cycles and sample only after the final one. This lets a wrapping accumulator produce a visibly different output.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    OP_MAC = 3'd0,
    OP_MAX = 3'd1,
    OP_MIN = 3'd2,
    OP_ADD = 3'd3,
    OP_CLR = 3'd4
  } pe_op_e;

  typedef enum logic [1:0] {
    ACT_BYP  = 2'd0,
    ACT_RELU = 2'd1,
    ACT_SIG  = 2'd2,
    ACT_TANH = 2'd3
  } pe_act_e;
endpackage

// File: rtl/pe_arith.sv
module pe_arith
  import pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 4
) (
  input  logic [2:0]               op_i,
  input  logic                     first_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [DATA_W-1:0] w_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic signed [ACC_W-1:0]  res_o,
  output logic                     emit_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_x, a_x, b_x, sat_sum;
  logic signed [SUM_W-1:0]  sum;

  assign prod   = a_i * w_i;
  assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign a_x    = {{(ACC_W-DATA_W){a_i[DATA_W-1]}}, a_i};
  assign b_x    = {{(ACC_W-DATA_W){b_i[DATA_W-1]}}, b_i};
  assign sum    = {acc_i[ACC_W-1], acc_i} + {prod_x[ACC_W-1], prod_x};

  // clamp on carry into the guard bit
  always_comb begin
    if (sum[SUM_W-1] != sum[SUM_W-2]) sat_sum = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
    else                               sat_sum = sum[ACC_W-1:0];
  end

  always_comb begin
    case (op_i)
      OP_MAC:  acc_o = first_i ? prod_x : sat_sum;
      OP_MAX:  acc_o = (first_i || (a_x > acc_i)) ? a_x : acc_i;
      OP_MIN:  acc_o = (first_i || (a_x < acc_i)) ? a_x : acc_i;
      OP_ADD:  acc_o = a_x + b_x;
      OP_CLR:  acc_o = '0;
      default: acc_o = acc_i;
    endcase
  end

  assign emit_o = (op_i == OP_MAC) || (op_i == OP_MAX) ||
                  (op_i == OP_MIN) || (op_i == OP_ADD);
  assign res_o  = (op_i == OP_MAC) ? (acc_o >>> FRAC_W) : acc_o;
endmodule

// File: rtl/pe_nonlin.sv
module pe_nonlin
  import pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 4
) (
  input  logic signed [ACC_W-1:0]  x_i,
  input  logic [1:0]               act_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int ONE   = 1 << FRAC_W;
  localparam int MAG_W = FRAC_W + 3;
  localparam logic [MAG_W-1:0] K_HALF = MAG_W'(ONE / 2);
  localparam logic [MAG_W-1:0] K_3Q   = MAG_W'((3 * ONE) / 4);
  localparam logic [MAG_W-1:0] K_ONE  = MAG_W'(ONE);
  localparam logic [MAG_W-1:0] K_TWO  = MAG_W'(2 * ONE);
  localparam logic [MAG_W-1:0] K_CAP  = MAG_W'(4 * ONE);
  localparam logic signed [ACC_W-1:0]  CAP_P  = ACC_W'(4 * ONE);
  localparam logic signed [ACC_W-1:0]  CAP_N  = -CAP_P;
  localparam logic signed [ACC_W-1:0]  OMAX   = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0]  OMIN   = ~OMAX;
  localparam logic signed [DATA_W-1:0] HALF_D = DATA_W'(ONE / 2);

  // odd-half curve: slopes 1, 1/2, 1/4, then flat at 1.0
  function automatic logic [MAG_W-1:0] pwl(input logic [MAG_W-1:0] u);
    if (u < K_HALF)     return u;
    else if (u < K_ONE) return K_HALF + ((u - K_HALF) >> 1);
    else if (u < K_TWO) return K_3Q + ((u - K_ONE) >> 2);
    else                return K_ONE;
  endfunction

  logic                     neg, big;
  logic signed [ACC_W-1:0]  ax;
  logic [MAG_W-1:0]         mag, tanh_m, sig_m;
  logic signed [DATA_W-1:0] t_s, s_s, xs;

  assign neg    = x_i[ACC_W-1];
  assign ax     = neg ? -x_i : x_i;
  assign big    = (x_i >= CAP_P) || (x_i <= CAP_N);
  assign mag    = big ? K_CAP : ax[MAG_W-1:0];
  assign tanh_m = pwl(mag);
  assign sig_m  = pwl(mag >> 1) >> 1;
  assign t_s    = DATA_W'(tanh_m);
  assign s_s    = DATA_W'(sig_m);

  always_comb begin
    if (x_i > OMAX)      xs = OMAX[DATA_W-1:0];
    else if (x_i < OMIN) xs = OMIN[DATA_W-1:0];
    else                 xs = x_i[DATA_W-1:0];
  end

  always_comb begin
    case (act_i)
      ACT_RELU: y_o = neg ? '0 : xs;
      ACT_SIG:  y_o = neg ? (HALF_D - s_s) : (HALF_D + s_s);
      ACT_TANH: y_o = neg ? -t_s : t_s;
      default:  y_o = xs;
    endcase
  end
endmodule

// File: rtl/opcfg_pe.sv
module opcfg_pe
  import pe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [2:0]               op_i,
  input  logic [1:0]               act_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [DATA_W-1:0] w_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     valid_o
);
  localparam logic signed [DATA_W-1:0] Y_ONE  = DATA_W'(1 << FRAC_W);
  localparam logic signed [DATA_W-1:0] Y_NONE = -Y_ONE;

  logic signed [ACC_W-1:0]  acc_q, acc_d, res;
  logic signed [DATA_W-1:0] y_q, y_d;
  logic                     vld_q, emit, fire;

  pe_arith #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_arith (
    .op_i(op_i), .first_i(first_i), .a_i(a_i), .b_i(b_i), .w_i(w_i),
    .acc_i(acc_q), .acc_o(acc_d), .res_o(res), .emit_o(emit)
  );

  pe_nonlin #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_nonlin (
    .x_i(res), .act_i(act_i), .y_o(y_d)
  );

  assign fire = valid_i && last_i && emit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire;
      if (valid_i) acc_q <= acc_d;
      if (fire)    y_q   <= y_d;
    end
  end

  assign y_o     = y_q;
  assign valid_o = vld_q;

  // R6
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i && last_i));
  // R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q));
  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CLR) |=> (acc_q == '0) && !valid_o);
  // R8
  relu_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && act_i == ACT_RELU) |=> !y_o[DATA_W-1]);
  // R10
  sig_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && act_i == ACT_SIG) |=> !y_o[DATA_W-1] && (y_o <= Y_ONE));
  // R9
  tanh_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && act_i == ACT_TANH) |=> (y_o >= Y_NONE) && (y_o <= Y_ONE));
endmodule

// File: tb/opcfg_pe_tb.sv
module opcfg_pe_tb;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [2:0]        op_i = '0;
  logic [1:0]        act_i = '0;
  logic              first_i = 1'b0;
  logic              last_i = 1'b0;
  logic signed [7:0] a_i = '0, b_i = '0, w_i = '0;
  logic signed [7:0] y_o;
  logic              valid_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  opcfg_pe u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .act_i(act_i), .first_i(first_i), .last_i(last_i), .a_i(a_i),
    .b_i(b_i), .w_i(w_i), .y_o(y_o), .valid_o(valid_o)
  );

  typedef struct packed {
    int op; int act; int first; int last;
    int a; int b; int w; int ev; int ey; int req;
  } vec_t;

  // op: 0 mac 1 max 2 min 3 add 4 clr; act: 0 byp 1 relu 2 sig 3 tanh
  localparam vec_t VEC [36] = '{
    '{0, 0, 1, 1,   32,    0,   24, 1,   48, 2},  // R2 load
    '{0, 0, 1, 0,   16,    0,   16, 0,    0, 2},  // R2 no output
    '{0, 0, 0, 1,   16,    0,   -8, 1,    8, 2},  // R2 accumulate
    '{0, 1, 1, 1,  -32,    0,   24, 1,    0, 8},  // R8 negative
    '{0, 1, 1, 1,   32,    0,   24, 1,   48, 8},  // R8 positive
    '{0, 0, 1, 1,  127,    0,  127, 1,  127, 7},  // R7 high
    '{0, 0, 1, 1, -128,    0,  127, 1, -128, 7},  // R7 low
    '{1, 0, 1, 0,   -5,    0,    0, 0,    0, 4},  // R4
    '{1, 0, 0, 0,  -20,    0,    0, 0,    0, 4},  // R4
    '{1, 0, 0, 1,    3,    0,    0, 1,    3, 4},  // R4 max
    '{2, 0, 1, 0,   10,    0,    0, 0,    0, 4},  // R4
    '{2, 0, 0, 0,   -7,    0,    0, 0,    0, 4},  // R4
    '{2, 0, 0, 1,   40,    0,    0, 1,   -7, 4},  // R4 min
    '{1, 0, 1, 1,  -60,    0,    0, 1,  -60, 4},  // R4 first reloads
    '{3, 0, 0, 1,  100,  -30,    0, 1,   70, 5},  // R5
    '{3, 0, 0, 1,  100,  100,    0, 1,  127, 7},  // R7
    '{3, 0, 0, 1, -100, -100,    0, 1, -128, 7},  // R7
    '{3, 3, 0, 1,   15,    5,    0, 1,   13, 9},  // R9
    '{3, 3, 0, 1,  -15,   -5,    0, 1,  -13, 9},  // R9
    '{3, 3, 0, 1,    3,    2,    0, 1,    5, 9},  // R9
    '{3, 3, 0, 1,  100,    0,    0, 1,   16, 9},  // R9
    '{3, 3, 0, 1,   10,    2,    0, 1,   10, 9},  // R9
    '{3, 2, 0, 1,   20,    0,    0, 1,   12, 10}, // R10
    '{3, 2, 0, 1,  -20,    0,    0, 1,    4, 10}, // R10
    '{3, 2, 0, 1,    5,    0,    0, 1,    9, 10}, // R10
    '{3, 2, 0, 1,   -5,    0,    0, 1,    7, 10}, // R10
    '{3, 2, 0, 1, -100,    0,    0, 1,    0, 10}, // R10
    '{3, 2, 0, 1,  100,    0,    0, 1,   16, 10}, // R10
    '{3, 2, 0, 1,    0,    0,    0, 1,    8, 10}, // R10
    '{3, 1, 0, 1,   -3,   -4,    0, 1,    0, 8},  // R8
    '{0, 3, 1, 1,   16,    0,   16, 1,   12, 9},  // R9 on mac path
    '{4, 0, 0, 1,    0,    0,    0, 0,    0, 3},  // R3 clear
    '{0, 0, 0, 1,   16,    0,   16, 1,   16, 3},  // R3 adds to zero
    '{5, 0, 1, 1,   99,    0,   99, 0,    0, 3},  // R3 unused opcode
    '{0, 0, 0, 1,   16,    0,    0, 1,   16, 3},  // R3 acc kept
    '{1, 0, 0, 1,  -50,    0,    0, 1,  127, 4}   // R4 compares with acc
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // sits just after a falling edge; returns at the next one
  task automatic drive(input int op, input int act, input int first, input int last,
                       input int a, input int b, input int w, input logic vld);
    valid_i = vld;
    op_i    = 3'(op);
    act_i   = 2'(act);
    first_i = first[0];
    last_i  = last[0];
    a_i     = 8'(a);
    b_i     = 8'(b);
    w_i     = 8'(w);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    summary_guard: begin end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 y_o in reset", int'(y_o), 0);
    chk("R1 valid_o in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid_o after release", int'(valid_o), 0);

    for (int i = 0; i < 36; i++) begin
      drive(VEC[i].op, VEC[i].act, VEC[i].first, VEC[i].last,
            VEC[i].a, VEC[i].b, VEC[i].w, 1'b1);
      chk($sformatf("R%0d row %0d valid_o", VEC[i].req, i), int'(valid_o), VEC[i].ev);
      if (VEC[i].ev != 0)
        chk($sformatf("R%0d row %0d y_o", VEC[i].req, i), int'(y_o), VEC[i].ey);
    end

    // R6 hold while valid_i low, single-cycle pulse, held y_o
    drive(0, 0, 1, 0, 16, 0, 16, 1'b1);
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 1, 1, 127, 0, 127, 1'b0);
      chk("R6 idle valid_o", int'(valid_o), 0);
    end
    drive(0, 0, 0, 1, 0, 0, 0, 1'b1);
    chk("R6 held acc valid_o", int'(valid_o), 1);
    chk("R6 held acc y_o", int'(y_o), 16);
    for (int k = 0; k < 2; k++) begin
      drive(3, 0, 0, 1, 50, 50, 0, 1'b0);
      chk("R6 pulse ends", int'(valid_o), 0);
      chk("R6 y_o held", int'(y_o), 16);
    end

    // R11 positive saturation then exact descent
    drive(0, 0, 1, 0, -128, 0, -128, 1'b1);
    for (int k = 1; k < 600; k++)
      drive(0, 0, 0, (k == 599) ? 1 : 0, -128, 0, -128, 1'b1);
    chk("R11 saturated y_o", int'(y_o), 127);
    for (int k = 0; k < 516; k++)
      drive(0, 0, 0, (k == 515) ? 1 : 0, 127, 0, -128, 1'b1);
    chk("R11 after saturation y_o", int'(y_o), 31);

    // R1 reset mid-stream clears outputs and accumulator
    drive(0, 0, 1, 1, 16, 0, 16, 1'b1);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    chk("R1 y_o mid reset", int'(y_o), 0);
    chk("R1 valid_o mid reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive(0, 0, 0, 1, 16, 0, 16, 1'b1);
    chk("R1 acc cleared by reset", int'(y_o), 16);

    summary();
  end
endmodule